// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a descriptor-driven Ethernet DMA engine. Software prepares a ring of descriptors in a small word-addressed descriptor RAM. Each descriptor is four 32-bit words, in this order: status, control, first buffer address and second buffer address. When a frame starts on the byte stream, the block reads the descriptor at its current pointer and checks the ownership bit. If the engine owns the descriptor, the block streams the frame bytes out as addressed byte writes into the first buffer. It then writes a packed status word back to the descriptor, which hands the descriptor back to the host, and it may raise a completion interrupt.

If the host still owns the descriptor, the block consumes the frame without storing it. It counts the frame as missed, pulses a buffer-unavailable flag and stays on the same descriptor. After a write-back, the pointer moves either to the ring base, to the next 16-byte slot, or to a linked descriptor, depending on two control bits.

The controller is a single state machine with these states:
- `S_IDLE` waits for a frame and leaves on `rx_valid`.
- `S_RQ_STAT` requests the status word.
- `S_CHK_OWN` tests ownership. It goes to `S_GET_CTRL` when the engine owns the descriptor, and to `S_DROP` otherwise.
- `S_GET_CTRL`, `S_GET_BUF1` and `S_GET_BUF2` collect the other three words, then move to `S_RECV`.
- `S_RECV` stores bytes and goes to `S_WBACK` on the last byte.
- `S_WBACK` writes the status word, advances the pointer and returns to `S_IDLE`.
- `S_DROP` discards bytes and returns to `S_IDLE` on the last byte.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, `rx_ready`, `dm_req`, `bw_valid`, `irq` and `bu_flag` are 0, `missed_cnt` is 0, and the first descriptor used is the one at word address `RING_BASE`.
- R2: A descriptor is read at word addresses ptr, ptr+1, ptr+2 and ptr+3, with read data arriving one cycle after the request. It is used only when bit 31 of its status word is 1. The status word written back at ptr always has bit 31 cleared.
- R3: The written-back status word holds the count of all frame bytes received, including the trailing 4 CRC bytes, in bits 29:16. Bits 9 and 8 are both set. With no error present, all other bits are 0.
- R4: Error inputs map to status bits as follows: `rx_err[0]` to bit 1 (CRC), `rx_err[1]` to bit 2 (dribble), `rx_err[2]` to bit 3 (receive), `rx_err[3]` to bit 4 (watchdog), `rx_err[4]` to bit 11 (overflow) and `rx_err[5]` to bit 12 (length). Bit 15 is set whenever any error bit is set. The inputs are sampled with the last byte.
- R5: Frame byte k is written to byte address buf1 + k, in arrival order, with the data unchanged. A write happens only in a cycle where a byte is accepted.
- R6: Control bits 10:0 give the buffer capacity. Bytes beyond that capacity are not written. In that case status bits 14 and 15 are set, and bits 29:16 still hold the full received count. A frame of exactly the capacity is not truncated.
- R7: After a write-back, if control bit 25 is set, the next descriptor is at `RING_BASE`. If neither bit 25 nor bit 24 is set, it is at ptr+4 words (16 bytes).
- R8: When control bit 24 is set and bit 25 is clear, the next descriptor is at word address (second-buffer word) / 4.
- R9: `irq` pulses for one cycle, the cycle after the status write, unless control bit 31 of that descriptor is set.
- R10: A frame arriving on a host-owned descriptor is consumed with no buffer write and no status write. `missed_cnt` increments by one, `bu_flag` pulses once, and the next frame uses the same descriptor.
- R11: `rx_ready` is low while a descriptor is being fetched or written back. It first rises 6 cycles after `rx_valid` is seen in idle for an owned descriptor, and 3 cycles after for a host-owned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of the frame |
| rx_err | input | 6 | Error flags, valid with the last byte |
| rx_ready | output | 1 | Block accepts the byte this cycle |
| dm_req | output | 1 | Descriptor RAM access request |
| dm_we | output | 1 | Descriptor RAM write enable |
| dm_addr | output | DM_AW | Descriptor RAM word address |
| dm_wdata | output | 32 | Descriptor RAM write data |
| dm_rdata | input | 32 | Descriptor RAM read data, one cycle after request |
| bw_valid | output | 1 | Buffer byte write strobe |
| bw_addr | output | 32 | Buffer byte address |
| bw_data | output | 8 | Buffer byte data |
| irq | output | 1 | Completion interrupt pulse |
| bu_flag | output | 1 | Buffer-unavailable pulse |
| missed_cnt | output | MISS_W | Count of frames dropped on host-owned descriptors |

## Verification
The hardest situation to reach from the ports is a host-owned descriptor in the middle of a live ring. The stimulus has to leave the pointer on a known slot and clear that slot's ownership bit. It then has to show that the pointer did not move, which it does by re-arming the same slot and checking where the next frame's status lands. The bench reaches this state after a table of frames walks the ring through its end-of-ring wrap. It then uses the re-armed slot as a chained descriptor, so the ownership stall, the link-following step and the final return to the base are all checked on consecutive frames.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RQ_STAT,
        S_CHK_OWN,
        S_GET_CTRL,
        S_GET_BUF1,
        S_GET_BUF2,
        S_RECV,
        S_DROP,
        S_WBACK
    } rxd_state_e;

    localparam int LEN_W   = 14;
    localparam int CAP_W   = 11;
    localparam int ERR_W   = 6;

    localparam int OWN_BIT   = 31;
    localparam int IRQD_BIT  = 31;
    localparam int EOR_BIT   = 25;
    localparam int CHAIN_BIT = 24;

endpackage

// File: rtl/rxd_status_pack.sv
module rxd_status_pack
    import rxd_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             trunc_i,
    output logic [31:0]      word_o
);

    always_comb begin
        word_o          = '0;
        word_o[29:16]   = len_i;
        word_o[9]       = 1'b1;
        word_o[8]       = 1'b1;
        word_o[1]       = err_i[0];
        word_o[2]       = err_i[1];
        word_o[3]       = err_i[2];
        word_o[4]       = err_i[3];
        word_o[11]      = err_i[4];
        word_o[12]      = err_i[5];
        word_o[14]      = trunc_i;
        word_o[15]      = trunc_i | (|err_i);
        word_o[OWN_BIT] = 1'b0;
    end

endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
    parameter int          DM_AW     = 8,
    parameter int unsigned RING_BASE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    input  logic             eor_i,
    input  logic             chain_i,
    input  logic [DM_AW-1:0] link_i,
    output logic [DM_AW-1:0] ptr_o
);

    localparam logic [DM_AW-1:0] BASE_W = DM_AW'(RING_BASE);
    localparam logic [DM_AW-1:0] STRIDE = DM_AW'(4);

    logic [DM_AW-1:0] ptr_q;
    logic [DM_AW-1:0] ptr_nx;

    always_comb begin
        if (eor_i)        ptr_nx = BASE_W;
        else if (chain_i) ptr_nx = link_i;
        else              ptr_nx = ptr_q + STRIDE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr_q <= BASE_W;
        else if (advance_i) ptr_q <= ptr_nx;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int          DM_AW     = 8,
    parameter int          MISS_W    = 8,
    parameter int unsigned RING_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              rx_ready,
    output logic              dm_req,
    output logic              dm_we,
    output logic [DM_AW-1:0]  dm_addr,
    output logic [31:0]       dm_wdata,
    input  logic [31:0]       dm_rdata,
    output logic              bw_valid,
    output logic [31:0]       bw_addr,
    output logic [7:0]        bw_data,
    output logic              irq,
    output logic              bu_flag,
    output logic [MISS_W-1:0] missed_cnt
);

    localparam logic [DM_AW-1:0] OFS1 = DM_AW'(1);
    localparam logic [DM_AW-1:0] OFS2 = DM_AW'(2);
    localparam logic [DM_AW-1:0] OFS3 = DM_AW'(3);

    rxd_state_e state_q, state_d;

    logic [DM_AW-1:0]  ptr;
    logic [CAP_W-1:0]  cap_q;
    logic              eor_q, chain_q, irqd_q;
    logic [31:0]       buf1_q;
    logic [DM_AW-1:0]  link_q;
    logic [LEN_W-1:0]  len_q;
    logic              trunc_q;
    logic [ERR_W-1:0]  err_q;
    logic              irq_q, bu_q;
    logic [MISS_W-1:0] miss_q;
    logic [31:0]       stat_word;
    logic              in_stream, take, room;

    assign in_stream = (state_q == S_RECV) || (state_q == S_DROP);
    assign take      = rx_valid && in_stream;
    assign room      = len_q < LEN_W'(cap_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (rx_valid) state_d = S_RQ_STAT;
            S_RQ_STAT:  state_d = S_CHK_OWN;
            S_CHK_OWN:  state_d = dm_rdata[OWN_BIT] ? S_GET_CTRL : S_DROP;
            S_GET_CTRL: state_d = S_GET_BUF1;
            S_GET_BUF1: state_d = S_GET_BUF2;
            S_GET_BUF2: state_d = S_RECV;
            S_RECV:     if (take && rx_last) state_d = S_WBACK;
            S_DROP:     if (take && rx_last) state_d = S_IDLE;
            S_WBACK:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Descriptor fields and frame accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            eor_q   <= 1'b0;
            chain_q <= 1'b0;
            irqd_q  <= 1'b0;
            buf1_q  <= '0;
            link_q  <= '0;
            len_q   <= '0;
            trunc_q <= 1'b0;
            err_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    len_q   <= '0;
                    trunc_q <= 1'b0;
                end
                S_GET_CTRL: begin
                    cap_q   <= dm_rdata[CAP_W-1:0];
                    eor_q   <= dm_rdata[EOR_BIT];
                    chain_q <= dm_rdata[CHAIN_BIT];
                    irqd_q  <= dm_rdata[IRQD_BIT];
                end
                S_GET_BUF1: buf1_q <= dm_rdata;
                S_GET_BUF2: link_q <= dm_rdata[DM_AW+1:2];
                S_RECV: if (take) begin
                    len_q <= len_q + 1'b1;
                    if (!room) trunc_q <= 1'b1;
                    if (rx_last) err_q <= rx_err;
                end
                default: ;
            endcase
        end
    end

    // Event pulses and missed-frame count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            bu_q   <= 1'b0;
            miss_q <= '0;
        end else begin
            irq_q <= (state_q == S_WBACK) && !irqd_q;
            bu_q  <= (state_q == S_DROP) && take && rx_last;
            if ((state_q == S_DROP) && take && rx_last) miss_q <= miss_q + 1'b1;
        end
    end

    rxd_status_pack u_pack (
        .len_i   (len_q),
        .err_i   (err_q),
        .trunc_i (trunc_q),
        .word_o  (stat_word)
    );

    rxd_ring_ptr #(
        .DM_AW     (DM_AW),
        .RING_BASE (RING_BASE)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (state_q == S_WBACK),
        .eor_i     (eor_q),
        .chain_i   (chain_q),
        .link_i    (link_q),
        .ptr_o     (ptr)
    );

    // Outputs
    always_comb begin
        rx_ready = in_stream;
        dm_req   = 1'b0;
        dm_we    = 1'b0;
        dm_addr  = ptr;
        dm_wdata = '0;
        bw_valid = 1'b0;
        bw_addr  = buf1_q + 32'(len_q);
        bw_data  = rx_data;
        unique case (state_q)
            S_RQ_STAT:  dm_req = 1'b1;
            S_CHK_OWN: begin
                dm_req  = dm_rdata[OWN_BIT];
                dm_addr = ptr + OFS1;
            end
            S_GET_CTRL: begin
                dm_req  = 1'b1;
                dm_addr = ptr + OFS2;
            end
            S_GET_BUF1: begin
                dm_req  = 1'b1;
                dm_addr = ptr + OFS3;
            end
            S_RECV:     bw_valid = rx_valid && room;
            S_WBACK: begin
                dm_req   = 1'b1;
                dm_we    = 1'b1;
                dm_wdata = stat_word;
            end
            default: ;
        endcase
    end

    assign irq        = irq_q;
    assign bu_flag    = bu_q;
    assign missed_cnt = miss_q;

endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              dm_req,
    input logic              dm_we,
    input logic              wb_own,
    input logic              bw_valid,
    input logic              irq,
    input logic              bu_flag,
    input logic [MISS_W-1:0] missed_cnt
);

    // R2: write-back hands the descriptor to the host
    a_r2_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !wb_own);

    // R9: interrupt only directly after a status write
    a_r9_irq_follows_wb: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(dm_we));

    // R10: each buffer-unavailable pulse counts exactly one missed frame
    a_r10_miss_counts: assert property (@(posedge clk) disable iff (!rst_n)
        bu_flag |-> (missed_cnt == $past(missed_cnt) + 1'b1));

    // R5: buffer writes only on accepted bytes
    a_r5_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> (rx_valid && rx_ready));

    // R11: no stream acceptance while the descriptor RAM is in use
    a_r11_no_ready_on_ram: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req |-> !rx_ready);

endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .dm_req     (dm_req),
    .dm_we      (dm_we),
    .wb_own     (dm_wdata[31]),
    .bw_valid   (bw_valid),
    .irq        (irq),
    .bu_flag    (bu_flag),
    .missed_cnt (missed_cnt)
);

// File: tb/rxd_ring_writer_tb.sv
module rxd_ring_writer_tb;

    localparam int DM_AW  = 8;
    localparam int MISS_W = 8;
    localparam int NVEC   = 7;

    localparam int          T_LEN [NVEC] = '{64, 10, 20, 40, 8, 5, 16};
    localparam logic [5:0]  T_FLG [NVEC] = '{6'h00, 6'h01, 6'h0A, 6'h00, 6'h30, 6'h04, 6'h00};
    localparam int          T_CAP [NVEC] = '{1536, 1536, 1536, 16, 1536, 1536, 16};
    localparam logic        T_IRD [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] T_EXP [NVEC] = '{32'h0040_0300, 32'h000A_8302, 32'h0014_8314,
                                             32'h0028_C300, 32'h0008_9B00, 32'h0005_8308,
                                             32'h0010_0300};
    localparam int          T_IRQ [NVEC] = '{1, 1, 0, 1, 1, 1, 1};
    localparam int          T_NWR [NVEC] = '{64, 10, 20, 16, 8, 5, 16};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_last = 1'b0;
    logic [5:0]        rx_err = '0;
    logic              rx_ready;
    logic              dm_req, dm_we;
    logic [DM_AW-1:0]  dm_addr;
    logic [31:0]       dm_wdata;
    logic [31:0]       dm_rdata = '0;
    logic              bw_valid;
    logic [31:0]       bw_addr;
    logic [7:0]        bw_data;
    logic              irq, bu_flag;
    logic [MISS_W-1:0] missed_cnt;

    logic              hw_we = 1'b0;
    logic [DM_AW-1:0]  hw_addr = '0;
    logic [31:0]       hw_wd = '0;
    logic [31:0]       dmem [256];

    int n_chk = 0;
    int n_fail = 0;
    int irq_tot = 0;
    int bu_tot = 0;
    int stall, wr_cnt, bad;
    logic [31:0] first_addr;

    always #5 clk = ~clk;

    rxd_ring_writer #(.DM_AW(DM_AW), .MISS_W(MISS_W), .RING_BASE(0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data),
        .irq(irq), .bu_flag(bu_flag), .missed_cnt(missed_cnt)
    );

    always @(posedge clk) begin
        if (hw_we) dmem[hw_addr] <= hw_wd;
        if (dm_req) begin
            if (dm_we) dmem[dm_addr] <= dm_wdata;
            else       dm_rdata <= dmem[dm_addr];
        end
    end

    always @(negedge clk) begin
        if (irq)     irq_tot++;
        if (bu_flag) bu_tot++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [31:0] d);
        hw_we = 1'b1; hw_addr = DM_AW'(a); hw_wd = d;
        @(negedge clk);
        hw_we = 1'b0;
    endtask

    task automatic arm(input int w, input logic [31:0] ctrl, input logic [31:0] b1, input logic [31:0] b2);
        host_wr(w, 32'h8000_0000);
        host_wr(w + 1, ctrl);
        host_wr(w + 2, b1);
        host_wr(w + 3, b2);
    endtask

    task automatic send_frame(input int n, input logic [5:0] fl, input logic [31:0] base);
        stall = 0; wr_cnt = 0; bad = 0; first_addr = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(k) ^ 8'h5A;
            rx_last  = (k == n - 1);
            rx_err   = (k == n - 1) ? fl : 6'h00;
            while (!rx_ready) begin
                stall++;
                @(negedge clk);
            end
            if (bw_valid) begin
                if (wr_cnt == 0) first_addr = bw_addr;
                if (bw_addr != base + 32'(k) || bw_data != rx_data) bad++;
                wr_cnt++;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int idx, irq0, bu0;
        logic [31:0] ctrl;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rx_ready", 32'(rx_ready), 0);
        check("R1 dm_req", 32'(dm_req), 0);
        check("R1 bw_valid", 32'(bw_valid), 0);
        check("R1 irq/bu", {30'd0, irq, bu_flag}, 0);
        check("R1 missed_cnt", 32'(missed_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: ring of four descriptors at words 0,4,8,12; slot 3 ends the ring
        idx = 0;
        for (int v = 0; v < NVEC; v++) begin
            ctrl = 32'(T_CAP[v]) | (32'(T_IRD[v]) << 31) | ((idx == 3) ? 32'h0200_0000 : 32'h0);
            arm(idx * 4, ctrl, 32'h1000 + 32'(idx) * 32'h100, 32'h0);
            irq0 = irq_tot;
            send_frame(T_LEN[v], T_FLG[v], 32'h1000 + 32'(idx) * 32'h100);
            check($sformatf("R3 R4 R6 R7 status vec%0d", v), dmem[idx * 4], T_EXP[v]);
            check($sformatf("R9 irq vec%0d", v), 32'(irq_tot - irq0), 32'(T_IRQ[v]));
            check($sformatf("R6 write count vec%0d", v), 32'(wr_cnt), 32'(T_NWR[v]));
            check($sformatf("R5 data/addr vec%0d", v), 32'(bad), 0);
            check($sformatf("R5 first addr vec%0d", v), first_addr, 32'h1000 + 32'(idx) * 32'h100);
            if (v == 0) check("R11 fetch stall", 32'(stall), 6);
            idx = (idx == 3) ? 0 : idx + 1;
        end

        // R10: slot at word 12 is host-owned
        host_wr(12, 32'h0);
        irq0 = irq_tot; bu0 = bu_tot;
        send_frame(12, 6'h00, 32'h0);
        check("R10 no buffer write", 32'(wr_cnt), 0);
        check("R10 status untouched", dmem[12], 32'h0);
        check("R10 missed_cnt", 32'(missed_cnt), 1);
        check("R10 bu pulse", 32'(bu_tot - bu0), 1);
        check("R10 no irq", 32'(irq_tot - irq0), 0);
        check("R11 drop stall", 32'(stall), 3);

        // R10 pointer held; same slot re-armed as a chained descriptor (R8)
        arm(12, 32'h0100_0000 | 32'd100, 32'h1300, 32'h0000_00A0);
        send_frame(12, 6'h00, 32'h1300);
        check("R10 same slot reused", dmem[12], 32'h000C_0300);
        check("R10 slot buffer", first_addr, 32'h1300);

        arm(40, 32'h0200_0000 | 32'd100, 32'h2000, 32'h0);
        send_frame(6, 6'h00, 32'h2000);
        check("R8 chained target status", dmem[40], 32'h0006_0300);
        check("R8 chained target buffer", first_addr, 32'h2000);

        arm(0, 32'd100, 32'h1000, 32'h0);
        send_frame(9, 6'h00, 32'h1000);
        check("R7 wrap to base", dmem[0], 32'h0009_0300);
        check("R2 own cleared", 32'(dmem[0][31]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule